// File: doc/BRIEF.md
# Double-Data-Rate Two-Word-Burst SRAM with Lane Write Masks

This block is a synthesizable model of a synchronous SRAM that moves data on both edges of its input clock pair. It has separate write and read data buses, and every command transfers two words. A single beat clock at twice the device rate stands in for the clock pair. Beats alternate between a rising phase and a falling phase, and the first beat after reset is a rising phase. A command can only be issued on a rising-phase beat.

A write places the first word at the loaded address and the second word at that address with bit 0 inverted. Each word has an active-low enable per lane, so the mask can differ between the two words of one burst. A read returns the same two locations in order. The read bus is released while no read data is present. The read data normally follows the output clock phase. When both output clocks are parked high, it follows the input clock instead, one beat earlier.

A command can be issued on every rising-phase beat, so bursts can run back to back. A read issued straight after a write sees the new data, even while the array update for that write is still pending.

Top module: `ddr2b_sram`

## Requirements
- R1: While reset is applied, and on the cycle after it, `rd_drive` is 0 and `rd_data` is all zeros. The first beat after reset is a rising-phase beat, and the phases then alternate.
- R2: `load_n` and `rd_sel` are sampled only on rising-phase beats. `load_n`=1 means no operation. Any values on these pins during a falling-phase beat cause no write and no read output.
- R3: A write (`load_n`=0, `rd_sel`=0) captures `wr_data` on its rising-phase beat for address A0. It captures `wr_data` again on the next falling-phase beat for address A0 with bit 0 inverted. Upper address bits are kept.
- R4: A read (`load_n`=0, `rd_sel`=1) returns the word at A0 first and then the word at A0 with bit 0 inverted, on consecutive beats.
- R5: Take a read command issued on beat b. With `oclk_parked`=0, `rd_drive` is 1 on beats b+2 and b+3. With `oclk_parked`=1, it is 1 on beats b+1 and b+2.
- R6: `lane_we_n[0]`=0 writes bits 8:0 and `lane_we_n[1]`=0 writes bits 17:9. A word written with both enables at 1 leaves the location unchanged.
- R7: The lane enables are sampled separately on each of the two beats of a write, so the two words of a burst can carry different masks.
- R8: When `rd_drive` is 0, `rd_data` is all zeros. This stands for the released bus.
- R9: Commands issued on consecutive rising-phase beats, with no idle beats between them, are each carried out in full.
- R10: A read issued on the rising-phase beat right after a write to the same pair of locations returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock: one period is one edge of the device clock pair |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low command strobe, rising-phase beats only |
| rd_sel | input | 1 | 1 selects read, 0 selects write |
| addr | input | ADDR_W | Burst start address A0 |
| wr_data | input | WORD_W | Write word for the current beat |
| lane_we_n | input | LANES | Active-low lane write enables for the current beat |
| oclk_parked | input | 1 | 1 when both output clocks are parked high, so reads follow the input clock |
| rd_data | output | WORD_W | Read word, zero while released |
| rd_drive | output | 1 | High while the read bus carries data |

## Verification
The assertions assume that `oclk_parked` changes only when no read is in flight. If it changed in the middle of a burst, the read window would be shifted partway through. The bench therefore changes the pin only after several idle beats. The stimulus issues commands on rising-phase beats and deliberately drives `load_n` low on falling-phase beats to show that those are ignored. It reads only locations that it has written since reset, so the contents of the uninitialised array never reach a check.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } burst_op_e;

    typedef enum logic {
        BEAT_RISE = 1'b0,
        BEAT_FALL = 1'b1
    } beat_e;

    function automatic burst_op_e decode_cmd(input logic strobe_n, input logic read_sel);
        if (strobe_n) begin
            return OP_IDLE;
        end
        return read_sel ? OP_READ : OP_WRITE;
    endfunction

    function automatic beat_e next_beat(input beat_e cur);
        return (cur == BEAT_RISE) ? BEAT_FALL : BEAT_RISE;
    endfunction

endpackage

// File: rtl/ddr2b_beat_ctrl.sv
module ddr2b_beat_ctrl
    import ddr2b_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] addr,
    output beat_e             beat,
    output burst_op_e         cur_op,
    output logic [ADDR_W-1:0] cur_addr
);

    burst_op_e         held_op;
    logic [ADDR_W-1:0] held_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat      <= BEAT_RISE;
            held_op   <= OP_IDLE;
            held_addr <= '0;
        end else begin
            beat <= next_beat(beat);
            if (beat == BEAT_RISE) begin
                held_op   <= cur_op;
                held_addr <= addr;
            end
        end
    end

    // Rising beat: decode the pins. Falling beat: replay the held command on the partner word.
    always_comb begin
        if (beat == BEAT_RISE) begin
            cur_op   = decode_cmd(load_n, rd_sel);
            cur_addr = addr;
        end else begin
            cur_op   = held_op;
            cur_addr = {held_addr[ADDR_W-1:1], ~held_addr[0]};
        end
    end

    assert_beat_alternates_R1: assert property (@(posedge clk) disable iff (rst)
        beat == BEAT_RISE |=> beat == BEAT_FALL);

    assert_fall_repeats_op_R2: assert property (@(posedge clk) disable iff (rst)
        beat == BEAT_FALL |-> cur_op == $past(cur_op));

    assert_partner_address_R3: assert property (@(posedge clk) disable iff (rst)
        (beat == BEAT_FALL && cur_op != OP_IDLE) |-> cur_addr == ($past(cur_addr) ^ ADDR_W'(1)));

endmodule

// File: rtl/ddr2b_store.sv
module ddr2b_store
    import ddr2b_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 18,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_op_e         op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  lane_we_n,
    output logic [WORD_W-1:0] rd_word
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = WORD_W / LANES;

    typedef struct packed {
        logic              valid;
        logic [LANES-1:0]  lanes;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wr_stage_t;

    logic [WORD_W-1:0] mem [DEPTH];
    wr_stage_t         stg;
    logic [WORD_W-1:0] arr_word;
    logic              hit;

    // Each beat's write is staged and committed one beat later.
    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg.valid <= (op == OP_WRITE);
            stg.lanes <= ~lane_we_n;
            stg.addr  <= addr;
            stg.data  <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (stg.valid && stg.lanes[l]) begin
                mem[stg.addr][l*LANE_W +: LANE_W] <= stg.data[l*LANE_W +: LANE_W];
            end
        end
    end

    assign arr_word = mem[addr];
    assign hit      = stg.valid && (stg.addr == addr);

    // Per-lane bypass of a commit that has not yet reached the array.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rd_word[l*LANE_W +: LANE_W] = (hit && stg.lanes[l])
                                           ? stg.data[l*LANE_W +: LANE_W]
                                           : arr_word[l*LANE_W +: LANE_W];
    end

    // Checker state: remembers the last commit so its effect on the array can be observed.
    logic              chk_v;
    logic [LANES-1:0]  chk_lanes;
    logic [ADDR_W-1:0] chk_addr;
    logic [WORD_W-1:0] chk_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_v     <= 1'b0;
            chk_lanes <= '0;
            chk_addr  <= '0;
            chk_data  <= '0;
        end else begin
            chk_v     <= stg.valid;
            chk_lanes <= stg.lanes;
            chk_addr  <= stg.addr;
            chk_data  <= stg.data;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        assert_lane_committed_R6: assert property (@(posedge clk) disable iff (rst)
            (chk_v && chk_lanes[l]) |->
                mem[chk_addr][l*LANE_W +: LANE_W] == chk_data[l*LANE_W +: LANE_W]);
    end

endmodule

// File: rtl/ddr2b_read_out.sv
module ddr2b_read_out
    import ddr2b_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_op_e         op,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              oclk_parked,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_drive
);

    logic              r1_v, r2_v;
    logic [WORD_W-1:0] r1_d, r2_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            r1_v <= 1'b0;
            r2_v <= 1'b0;
            r1_d <= '0;
            r2_d <= '0;
        end else begin
            r1_v <= (op == OP_READ);
            r1_d <= (op == OP_READ) ? rd_word : '0;
            r2_v <= r1_v;
            r2_d <= r1_d;
        end
    end

    // Parked output clocks: tap the first stage. Otherwise tap the second.
    assign rd_drive = oclk_parked ? r1_v : r2_v;
    assign rd_data  = oclk_parked ? r1_d : r2_d;

    assert_released_after_reset_R1: assert property (@(posedge clk)
        rst |=> !rd_drive);

    assert_two_beat_window_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_drive) |=> rd_drive);

    assert_released_bus_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_drive |-> rd_data == '0);

endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
    import ddr2b_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 18,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              oclk_parked,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_drive
);

    beat_e             beat;
    burst_op_e         cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] rd_word;

    ddr2b_beat_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load_n   (load_n),
        .rd_sel   (rd_sel),
        .addr     (addr),
        .beat     (beat),
        .cur_op   (cur_op),
        .cur_addr (cur_addr)
    );

    ddr2b_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .op        (cur_op),
        .addr      (cur_addr),
        .wdata     (wr_data),
        .lane_we_n (lane_we_n),
        .rd_word   (rd_word)
    );

    ddr2b_read_out #(.WORD_W(WORD_W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .op          (cur_op),
        .rd_word     (rd_word),
        .oclk_parked (oclk_parked),
        .rd_data     (rd_data),
        .rd_drive    (rd_drive)
    );

endmodule

// File: tb/ddr2b_sram_tb.sv
`timescale 1ns/1ps
module ddr2b_sram_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_n = 1'b1;
    logic        rd_sel = 1'b0;
    logic [5:0]  addr = '0;
    logic [17:0] wr_data = '0;
    logic [1:0]  lane_we_n = 2'b11;
    logic        oclk_parked = 1'b0;
    logic [17:0] rd_data;
    logic        rd_drive;

    always #2.5 clk = ~clk;

    ddr2b_sram u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .rd_sel(rd_sel), .addr(addr),
        .wr_data(wr_data), .lane_we_n(lane_we_n), .oclk_parked(oclk_parked),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int drv = 0;
    bit finished = 0;
    string cur_tag = "R8";

    logic [17:0] shadow [64];
    logic [17:0] exp_q [int];
    string       exp_tag [int];
    int          rise_op = 0;
    logic [5:0]  rise_addr = '0;

    // Behavioural reference: zero-latency array, reads scheduled by latency.
    always @(posedge clk) begin
        int lat;
        int op;
        logic [5:0] a;
        if (rst) begin
            cyc = 0;
            rise_op = 0;
        end else begin
            lat = oclk_parked ? 1 : 2;
            if (cyc % 2 == 0) begin
                op = load_n ? 0 : (rd_sel ? 1 : 2);
                a = addr;
                rise_op = op;
                rise_addr = addr;
            end else begin
                op = rise_op;
                a = rise_addr ^ 6'd1;
            end
            if (op == 2) begin
                for (int l = 0; l < 2; l++) begin
                    if (!lane_we_n[l]) shadow[a][l*9 +: 9] = wr_data[l*9 +: 9];
                end
            end
            if (op == 1) begin
                exp_q[cyc + lat] = shadow[a];
                exp_tag[cyc + lat] = cur_tag;
            end
            cyc++;
        end
    end

    task automatic check_out();
        logic [17:0] eq;
        logic        ev;
        string       tg;
        if (exp_q.exists(cyc)) begin
            eq = exp_q[cyc]; ev = 1'b1; tg = exp_tag[cyc];
        end else begin
            eq = '0; ev = 1'b0; tg = "R8";
        end
        checks++;
        if (rd_drive !== ev || rd_data !== eq) begin
            failures++;
            $display("FAIL %s beat %0d: drive=%0b data=%h expected drive=%0b data=%h",
                     tg, cyc, rd_drive, rd_data, ev, eq);
        end
    endtask

    task automatic beat_in(input bit ld, input bit rd, input logic [5:0] a,
                           input logic [17:0] dd, input logic [1:0] bw, input string tag);
        @(negedge clk);
        check_out();
        rst = 1'b0;
        load_n = ld; rd_sel = rd; addr = a; wr_data = dd; lane_we_n = bw; cur_tag = tag;
        drv++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) beat_in(1'b1, 1'b0, 6'd0, 18'd0, 2'b11, "R8");
    endtask

    task automatic align();
        if (drv % 2 != 0) idle(1);
    endtask

    task automatic wr(input logic [5:0] a, input logic [17:0] d0, input logic [1:0] m0,
                      input logic [17:0] d1, input logic [1:0] m1, input string tag);
        align();
        beat_in(1'b0, 1'b0, a, d0, m0, tag);
        beat_in(1'b1, 1'b0, 6'd0, d1, m1, tag);
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        align();
        beat_in(1'b0, 1'b1, a, 18'h3ffff, 2'b00, tag);
        beat_in(1'b1, 1'b0, 6'd0, 18'h3ffff, 2'b00, tag);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired at beat %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rd_drive !== 1'b0 || rd_data !== 18'd0) begin
            failures++;
            $display("FAIL R1 reset: drive=%0b data=%h expected drive=0 data=0", rd_drive, rd_data);
        end
        // R1: output stays released on the first beats after reset
        idle(2);

        // R3/R4: full-mask writes at even and odd starting addresses, then reads
        wr(6'd4, 18'h2a5a5, 2'b00, 18'h15a5a, 2'b00, "R3");
        wr(6'd9, 18'h3c00f, 2'b00, 18'h003f0, 2'b00, "R3");
        rd(6'd4, "R4");
        rd(6'd9, "R4");
        rd(6'd5, "R4");
        idle(4);

        // R9: back-to-back writes and reads
        wr(6'd10, 18'h11111, 2'b00, 18'h22222, 2'b00, "R9");
        wr(6'd12, 18'h33333, 2'b00, 18'h04444, 2'b00, "R9");
        wr(6'd14, 18'h05555, 2'b00, 18'h36666, 2'b00, "R9");
        rd(6'd10, "R9");
        rd(6'd12, "R9");
        rd(6'd15, "R9");
        idle(4);

        // R6/R7: lane masks, different per word, and a fully masked write
        wr(6'd20, 18'h3ffff, 2'b00, 18'h3ffff, 2'b00, "R6");
        wr(6'd20, 18'h00000, 2'b10, 18'h00000, 2'b01, "R7");
        rd(6'd20, "R7");
        wr(6'd22, 18'h12345, 2'b00, 18'h2abcd, 2'b00, "R6");
        wr(6'd22, 18'h00000, 2'b11, 18'h00000, 2'b11, "R6");
        rd(6'd22, "R6");
        idle(4);

        // R2: strobe on falling beats must be ignored (write and read attempts)
        align();
        beat_in(1'b1, 1'b0, 6'd0, 18'd0, 2'b11, "R2");
        beat_in(1'b0, 1'b0, 6'd4, 18'h3ffff, 2'b00, "R2");
        beat_in(1'b1, 1'b0, 6'd0, 18'd0, 2'b11, "R2");
        beat_in(1'b0, 1'b1, 6'd4, 18'h3ffff, 2'b00, "R2");
        idle(4);
        rd(6'd4, "R2");
        idle(4);

        // R10: read straight after write to the same pair
        wr(6'd30, 18'h0beef, 2'b00, 18'h1cafe, 2'b00, "R10");
        rd(6'd30, "R10");
        wr(6'd31, 18'h00000, 2'b01, 18'h3ffff, 2'b10, "R10");
        rd(6'd30, "R10");
        idle(4);

        // R5: parked output clocks shorten latency by one beat
        oclk_parked = 1'b1;
        idle(4);
        wr(6'd40, 18'h0f0f0, 2'b00, 18'h30303, 2'b00, "R5");
        rd(6'd40, "R5");
        rd(6'd4, "R5");
        rd(6'd41, "R5");
        idle(4);
        oclk_parked = 1'b0;
        idle(4);
        rd(6'd40, "R5");
        idle(6);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule